// File: doc/BRIEF.md
# Synchronous SRAM Data-Side Write and Output Control

This block is the data half of a synchronous flowthrough SRAM organised in byte lanes, each lane carrying eight data bits and one parity bit. An address sequencer upstream hands it a registered word address, a device-select flag and a flag marking the first clock of a cycle opened by the processor strobe. The block samples the global write, the byte write enable, the per-lane byte selects and the write data on the rising clock edge, decides per lane whether to write, and commits the write to an internal array one edge later.

Reads return the word addressed at the capture edge on a registered read port. A separate drive-enable output tells the pad logic when the bidirectional data bus may be driven. That output combines the asynchronous active-low output enable with a registered "read data valid" term. The registered term is cleared after writes, after deselected or sleeping cycles, and on the first read after the device leaves the deselected state. A sleep input blocks all access while keeping the array contents intact.

Top module: `sram_data_ctrl`

## Requirements
- R1: With `gw_n` low on a selected, non-processor-start, awake cycle, all lanes are written (data byte i at `wdata[8i+7:8i]` and parity bit `wpar[i]`), whatever `bwe_n` and `bsel_n` are.
- R2: With `gw_n` high, lane i is written only when `bwe_n` is low and `bsel_n[i]` is low; a cycle where no lane is written is a read, so low byte selects without `bwe_n` write nothing.
- R3: Parity bit i is written under the same condition as data byte i, and is returned on `rpar[i]` next to that byte.
- R4: A write captured at edge k is in the array at edge k+1. A read captured at edge k places the addressed word on `rdata`/`rpar` after edge k+1. `rdata` holds its value on cycles that are not reads.
- R5: `dq_oe` is high only while the registered read data is valid and `oe_n` is low, and follows `oe_n` without waiting for a clock edge.
- R6: `dq_oe` stays low for the result slot of a write cycle, a deselected cycle, and the first read after a deselected or sleeping cycle, regardless of `oe_n`.
- R7: While `sleep` is high the cycle counts as deselected: nothing is written, nothing is read, and the array contents are kept.
- R8: A selected cycle with `acc_pstart` high is a read; `gw_n`, `bwe_n` and `bsel_n` have no effect in it.
- R9: After synchronous reset `rdata`, `rpar` and `dq_oe` are zero, and the first selected cycle after reset counts as leaving the deselected state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_sel | input | 1 | Device selected this cycle (from the address sequencer) |
| acc_pstart | input | 1 | First clock of a processor-strobe cycle |
| acc_addr | input | ADDR_W | Registered word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES | Per-lane byte selects, active low |
| wdata | input | LANES*BYTE_W | Write data, lane i at bits 8i+7..8i |
| wpar | input | LANES | Write parity, one bit per lane |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | LANES*BYTE_W | Registered read data |
| rpar | output | LANES | Registered read parity |
| dq_oe | output | 1 | Drive enable for the bidirectional data bus |

## Verification
The bench builds the block with its defaults: four lanes of eight bits plus parity and a sixteen-word array. Four lanes are enough to mix written and untouched lanes inside one word, so byte masking and the way parity follows the data are visible in single read-backs. The small depth lets a handful of addresses be written, overwritten and read back to show that ignored writes under sleep and processor-start cycles left the array unchanged.

// File: rtl/sram_dc_pkg.sv
package sram_dc_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int PAR_PER_LANE = 1;

endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
  import sram_dc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW    = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_sel,
  input  logic              acc_pstart,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic [DW-1:0]     wdata,
  input  logic [LANES-1:0]  wpar,
  input  logic              sleep,
  output logic [ADDR_W-1:0] s_addr,
  output logic [LANES-1:0]  s_wmask,
  output logic [DW-1:0]     s_wdata,
  output logic [LANES-1:0]  s_wpar,
  output op_e               s_op,
  output logic              s_first
);

  logic             eff_sel;
  logic             wr_allowed;
  logic [LANES-1:0] lane_wr;
  logic             prev_sel_q;
  op_e              op_d;

  // sleep behaves as a deselect (R7)
  assign eff_sel    = acc_sel & ~sleep;
  // processor-start cycles never write (R8)
  assign wr_allowed = eff_sel & ~acc_pstart;

  for (genvar i = 0; i < LANES; i++) begin : g_lane_dec
    // global write wins; otherwise byte enable qualified by lane select (R1, R2, R3)
    assign lane_wr[i] = wr_allowed & (~gw_n | (~bwe_n & ~bsel_n[i]));
  end

  always_comb begin
    if (!eff_sel)       op_d = OP_IDLE;
    else if (|lane_wr)  op_d = OP_WRITE;
    else                op_d = OP_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_addr     <= '0;
      s_wmask    <= '0;
      s_wdata    <= '0;
      s_wpar     <= '0;
      s_op       <= OP_IDLE;
      s_first    <= 1'b1;
      prev_sel_q <= 1'b0;
    end else begin
      s_addr     <= acc_addr;
      s_wmask    <= lane_wr;
      s_wdata    <= wdata;
      s_wpar     <= wpar;
      s_op       <= op_d;
      s_first    <= ~prev_sel_q;
      prev_sel_q <= eff_sel;
    end
  end

  a_r1_global_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (acc_sel && !sleep && !acc_pstart && !gw_n) |=> (s_wmask == {LANES{1'b1}}));

  a_r2_no_bwe_no_write: assert property (@(posedge clk) disable iff (rst)
    (gw_n && bwe_n) |=> (s_wmask == '0));

  a_r7_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (s_op == OP_IDLE && s_wmask == '0));

  a_r8_pstart_reads: assert property (@(posedge clk) disable iff (rst)
    (acc_sel && !sleep && acc_pstart) |=> (s_op == OP_READ && s_wmask == '0));

endmodule

// File: rtl/sram_lane_mem.sv
module sram_lane_mem #(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);

  logic [LANE_W-1:0] mem [DEPTH];

  // write port: no reset, single address, block-RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  // registered read port with synchronous reset of the output register
  always_ff @(posedge clk) begin
    if (rst)     rd <= '0;
    else if (re) rd <= mem[addr];
  end

endmodule

// File: rtl/sram_out_ctrl.sv
module sram_out_ctrl
  import sram_dc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  op_e  s_op,
  input  logic s_first,
  input  logic oe_n,
  output logic dq_oe
);

  logic rd_valid_q;

  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= (s_op == OP_READ) && !s_first;
  end

  // asynchronous gating by the output enable (R5)
  assign dq_oe = rd_valid_q & ~oe_n;

  a_r6_first_read_blank: assert property (@(posedge clk) disable iff (rst)
    s_first |=> !rd_valid_q);

  a_r6_nonread_blank: assert property (@(posedge clk) disable iff (rst)
    (s_op != OP_READ) |=> !dq_oe);

  a_r4_valid_from_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid_q |-> ($past(s_op) == OP_READ));

endmodule

// File: rtl/sram_data_ctrl.sv
module sram_data_ctrl
  import sram_dc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW     = LANES * BYTE_W,
  localparam int LANE_W = BYTE_W + PAR_PER_LANE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_sel,
  input  logic              acc_pstart,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic [DW-1:0]     wdata,
  input  logic [LANES-1:0]  wpar,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DW-1:0]     rdata,
  output logic [LANES-1:0]  rpar,
  output logic              dq_oe
);

  logic [ADDR_W-1:0] s_addr;
  logic [LANES-1:0]  s_wmask;
  logic [DW-1:0]     s_wdata;
  logic [LANES-1:0]  s_wpar;
  op_e               s_op;
  logic              s_first;
  logic              s_re;

  sram_wr_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)
  ) u_dec (
    .clk(clk), .rst(rst),
    .acc_sel(acc_sel), .acc_pstart(acc_pstart), .acc_addr(acc_addr),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .wdata(wdata), .wpar(wpar), .sleep(sleep),
    .s_addr(s_addr), .s_wmask(s_wmask), .s_wdata(s_wdata),
    .s_wpar(s_wpar), .s_op(s_op), .s_first(s_first)
  );

  assign s_re = (s_op == OP_READ);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane_rd;

    sram_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk(clk), .rst(rst),
      .we(s_wmask[i]), .re(s_re), .addr(s_addr),
      .wd({s_wpar[i], s_wdata[i*BYTE_W +: BYTE_W]}),
      .rd(lane_rd)
    );

    assign rdata[i*BYTE_W +: BYTE_W] = lane_rd[BYTE_W-1:0];
    assign rpar[i]                   = lane_rd[BYTE_W];
  end

  sram_out_ctrl u_out (
    .clk(clk), .rst(rst),
    .s_op(s_op), .s_first(s_first), .oe_n(oe_n),
    .dq_oe(dq_oe)
  );

  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!dq_oe && rdata == '0 && rpar == '0));

  a_r7_sleep_holds_data: assert property (@(posedge clk) disable iff (rst)
    $past(s_op) == OP_IDLE |-> $stable(rdata));

endmodule

// File: tb/sim_sram_data_ctrl.sv
module sim_sram_data_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_sel, acc_pstart;
  logic [3:0]  acc_addr;
  logic        gw_n, bwe_n;
  logic [3:0]  bsel_n;
  logic [31:0] wdata;
  logic [3:0]  wpar;
  logic        oe_n, sleep;
  logic [31:0] rdata;
  logic [3:0]  rpar;
  logic        dq_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sram_data_ctrl u0 (
    .clk(clk), .rst(rst), .acc_sel(acc_sel), .acc_pstart(acc_pstart),
    .acc_addr(acc_addr), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .wdata(wdata), .wpar(wpar), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rpar(rpar), .dq_oe(dq_oe)
  );

  typedef struct packed {
    logic        sel, ps, gw_n, bwe_n;
    logic [3:0]  bsel_n, addr;
    logic [31:0] wd;
    logic [3:0]  wp;
    logic        oe_n, slp, chk, eoe;
    logic [31:0] ed;
    logic [3:0]  ep;
  } vec_t;

  localparam int NV = 20;
  // lane i = wdata[8i+7:8i], parity wpar[i]; result of row j is checked two clocks later
  localparam vec_t VEC [NV] = '{
    '{1,0,0,1,4'hF,4'h2,32'h00000000,4'h0,0,0,0,0,32'h0,4'h0},        // R1 clear addr2
    '{1,0,0,1,4'hF,4'h1,32'h11223344,4'hF,0,0,0,0,32'h0,4'h0},        // R1 fill addr1
    '{1,0,1,0,4'hA,4'h2,32'hAABBCCDD,4'hF,0,0,0,0,32'h0,4'h0},        // R2 R3 lanes 0,2
    '{1,0,1,1,4'h0,4'h1,32'hFFFFFFFF,4'h0,0,0,1,1,32'h11223344,4'hF}, // R2 bsel w/o bwe reads
    '{1,0,1,1,4'hF,4'h2,32'h0,4'h0,0,0,1,1,32'h00BB00DD,4'h5},        // R3 R4 masked word
    '{1,0,1,1,4'hF,4'h1,32'h0,4'h0,1,0,1,0,32'h11223344,4'hF},        // R5 oe_n high
    '{1,1,0,1,4'hF,4'h1,32'hDEADBEEF,4'h0,0,0,1,1,32'h11223344,4'hF}, // R8 pstart read
    '{1,0,1,1,4'hF,4'h1,32'h0,4'h0,0,0,1,1,32'h11223344,4'hF},        // R8 no write happened
    '{0,0,0,1,4'hF,4'h1,32'h0,4'h0,0,0,0,0,32'h0,4'h0},               // R6 deselected
    '{1,0,1,1,4'hF,4'h1,32'h0,4'h0,0,0,1,0,32'h11223344,4'hF},        // R6 first after deselect
    '{1,0,1,1,4'hF,4'h2,32'h0,4'h0,0,0,1,1,32'h00BB00DD,4'h5},        // R5 driven
    '{1,0,0,1,4'hF,4'h2,32'hFFFFFFFF,4'hF,0,1,0,0,32'h0,4'h0},        // R7 sleep write
    '{1,0,1,1,4'hF,4'h2,32'h0,4'h0,0,0,1,0,32'h00BB00DD,4'h5},        // R7 R6 first after sleep
    '{1,0,1,1,4'hF,4'h2,32'h0,4'h0,0,0,1,1,32'h00BB00DD,4'h5},        // R7 contents kept
    '{1,0,0,1,4'hF,4'h3,32'hCAFEF00D,4'hA,0,0,0,0,32'h0,4'h0},        // R1 gw over masks
    '{1,0,1,1,4'hF,4'h3,32'h0,4'h0,0,0,1,1,32'hCAFEF00D,4'hA},        // R1 readback
    '{1,0,1,0,4'h7,4'h3,32'h12000000,4'h0,0,0,0,0,32'h0,4'h0},        // R3 lane 3 only
    '{1,0,1,1,4'hF,4'h3,32'h0,4'h0,0,0,1,1,32'h12FEF00D,4'h2},        // R3 parity follows
    '{0,0,1,1,4'hF,4'h0,32'h0,4'h0,1,0,0,0,32'h0,4'h0},               // idle
    '{0,0,1,1,4'hF,4'h0,32'h0,4'h0,1,0,0,0,32'h0,4'h0}                // idle
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    acc_sel = 0; acc_pstart = 0; acc_addr = '0; gw_n = 1; bwe_n = 1;
    bsel_n = '1; wdata = '0; wpar = '0; sleep = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    drive_idle();
    oe_n = 0;
    rst  = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset dq_oe", {63'b0, dq_oe}, 64'd0);
    check("R9 reset rdata", {28'b0, rpar, rdata}, 64'd0);
    rst = 0;

    for (int j = 0; j < NV; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        oe_n = VEC[j-2].oe_n;
        #1;
        check($sformatf("R5 R6 row %0d dq_oe", j-2), {63'b0, dq_oe}, {63'b0, VEC[j-2].eoe});
        if (VEC[j-2].chk)
          check($sformatf("R4 row %0d data", j-2), {28'b0, rpar, rdata},
                {28'b0, VEC[j-2].ep, VEC[j-2].ed});
      end
      acc_sel = VEC[j].sel; acc_pstart = VEC[j].ps; gw_n = VEC[j].gw_n;
      bwe_n = VEC[j].bwe_n; bsel_n = VEC[j].bsel_n; acc_addr = VEC[j].addr;
      wdata = VEC[j].wd; wpar = VEC[j].wp; sleep = VEC[j].slp;
    end

    // R5: output enable acts without a clock edge
    @(negedge clk);
    oe_n = 0; acc_sel = 1; acc_addr = 4'h1;   // warm-up read (first after idle)
    @(negedge clk);                            // second read: valid
    @(negedge clk);
    drive_idle();
    @(posedge clk);
    #2;
    check("R5 async oe low", {63'b0, dq_oe}, 64'd1);
    check("R4 read addr1", {28'b0, rpar, rdata}, {28'b0, 4'hF, 32'h11223344});
    oe_n = 1; #1;
    check("R5 async oe high", {63'b0, dq_oe}, 64'd0);
    oe_n = 0; #1;
    check("R5 async oe low again", {63'b0, dq_oe}, 64'd1);
    @(posedge clk); #2;
    check("R6 deselect blanks", {63'b0, dq_oe}, 64'd0);

    // R9: reset clears a live output
    @(negedge clk);
    acc_sel = 1; acc_addr = 4'h3;
    repeat (2) @(negedge clk);
    rst = 1;
    @(negedge clk);
    check("R9 reset clears dq_oe", {63'b0, dq_oe}, 64'd0);
    check("R9 reset clears rdata", {28'b0, rpar, rdata}, 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule